// File: doc/BRIEF.md
# Shared-ALU Product Engine

This block computes s = n·(n+a) for two unsigned operands. It uses no multiplier. One four-function ALU is shared by every step of the calculation, and a small controller sequences it.

A start pulse captures n into working register R1 and a into working register R2. The engine then proceeds in this order:

1. It forms the sum m = n + a in R2.
2. It copies n into a down-counter.
3. It clears R1.
4. It adds m into R1 once for each count, decrementing the counter through the same ALU after each addition.

When the counter reaches zero, R1 holds s. A one-cycle done pulse follows, and the engine returns to idle.

The result register is 2·W+1 bits wide, where W is the operand width. This width holds the largest possible product, so no result is truncated. The block is split into three parts: a controller, a datapath holding the registers and source multiplexer, and the ALU. Every register changes only on the rising clock edge. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `repadd_mul`

## Requirements
- R1: While reset is applied, and once it has been released, done is 0 and result is 0. A reset during a calculation abandons it: no done pulse is produced and result returns to 0.
- R2: At the done pulse, result equals n·(n+a), computed from the operands sampled with the accepted start. The result is 2·W+1 bits wide, so no wrap is possible.
- R3: done is high for exactly one clock cycle per accepted start.
- R4: Count the rising edges after the edge that accepts start. The first edge after which done is high is edge 3+3·n.
- R5: A start is accepted only in the idle state. A start or operand change during a calculation has no effect on that calculation's result or timing.
- R6: Outside a calculation, result holds its value until the next accepted start, whatever n and a do.
- R7: The ALU select codes are fixed as follows:
  - 00 passes B.
  - 01 gives B minus carry-in.
  - 10 gives B plus carry-in.
  - 11 gives A plus B.
  
  All four are computed modulo 2^(2·W+1).
- R8: With n = 0, the calculation makes no accumulation step. It finishes three edges after start with result 0, whatever a is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a calculation; sampled only while idle |
| n_in | input | W | Operand n (unsigned) |
| a_in | input | W | Operand a (unsigned) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2·W+1 | Contents of R1; equals n·(n+a) at done |

## Verification
The hardest situation to reach from the ports is a second start that arrives while the loop is partway through. That start carries different operands, and it must leave both the product and the cycle count of the running calculation untouched. The stimulus raises start with new n and a several edges into a run, while the loop is between its test, add and decrement steps. The bench then confirms that the original product arrives on the original edge. A reset applied mid-loop and the n = 0 bypass of the loop are also driven directly. The largest operands are included, which produces a product that needs every result bit.

// File: rtl/repadd_mul_pkg.sv
package repadd_mul_pkg;

  // ALU function select; the code values are part of the block's contract
  typedef enum logic [1:0] {
    FN_PASS_B = 2'b00,
    FN_DEC_B  = 2'b01,
    FN_INC_B  = 2'b10,
    FN_ADD_AB = 2'b11
  } alu_fn_e;

  // B operand source for the shared ALU
  typedef enum logic [1:0] {
    BSRC_R2   = 2'b00,
    BSRC_CNT  = 2'b01,
    BSRC_ZERO = 2'b10
  } bsrc_e;

  // Controller flowchart steps
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SUM  = 3'd1,
    ST_CLR  = 3'd2,
    ST_TEST = 3'd3,
    ST_ACC  = 3'd4,
    ST_STEP = 3'd5,
    ST_FIN  = 3'd6
  } ctl_st_e;

endpackage

// File: rtl/repadd_mul_rst_sync.sv
module repadd_mul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/repadd_mul_alu.sv
module repadd_mul_alu
  import repadd_mul_pkg::*;
#(
  parameter int DW = 17
) (
  input  alu_fn_e         fn,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            c0,
  output logic [DW-1:0]   y
);

  logic [DW-1:0] c0_ext;

  assign c0_ext = {{(DW-1){1'b0}}, c0};

  always_comb begin
    unique case (fn)
      FN_PASS_B: y = b;
      FN_DEC_B:  y = b - c0_ext;
      FN_INC_B:  y = b + c0_ext;
      FN_ADD_AB: y = a + b;
      default:   y = b;
    endcase
  end

endmodule

// File: rtl/repadd_mul_datapath.sv
module repadd_mul_datapath
  import repadd_mul_pkg::*;
#(
  parameter int OW = 8,
  parameter int DW = 2*OW+1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OW-1:0]   n_in,
  input  logic [OW-1:0]   a_in,
  input  logic            ld_ops,
  input  bsrc_e           b_src,
  input  logic            r1_we,
  input  logic            r2_we,
  input  logic            cnt_we,
  input  logic            cnt_ld_r1,
  input  logic [DW-1:0]   alu_y,
  output logic [DW-1:0]   alu_a,
  output logic [DW-1:0]   alu_b,
  output logic [DW-1:0]   r1_q,
  output logic            cnt_zero
);

  localparam int PADW = DW - OW;

  logic [DW-1:0] r2_q;
  logic [OW-1:0] cnt_q;
  logic [DW-1:0] r1_d;
  logic [DW-1:0] r2_d;
  logic [OW-1:0] cnt_d;

  // operand A is always R1; B comes from the source multiplexer
  assign alu_a = r1_q;

  always_comb begin
    unique case (b_src)
      BSRC_R2:   alu_b = r2_q;
      BSRC_CNT:  alu_b = {{PADW{1'b0}}, cnt_q};
      BSRC_ZERO: alu_b = '0;
      default:   alu_b = '0;
    endcase
  end

  // next-value selection
  always_comb begin
    r1_d  = ld_ops ? {{PADW{1'b0}}, n_in} : alu_y;
    r2_d  = ld_ops ? {{PADW{1'b0}}, a_in} : alu_y;
    cnt_d = cnt_ld_r1 ? r1_q[OW-1:0] : alu_y[OW-1:0];
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= '0;
    end else if (r1_we) begin
      r1_q <= r1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r2_q <= '0;
    end else if (r2_we) begin
      r2_q <= r2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/repadd_mul_ctrl.sv
module repadd_mul_ctrl
  import repadd_mul_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     cnt_zero,
  output logic     ld_ops,
  output alu_fn_e  alu_fn,
  output logic     alu_c0,
  output bsrc_e    b_src,
  output logic     r1_we,
  output logic     r2_we,
  output logic     cnt_we,
  output logic     cnt_ld_r1,
  output logic     done
);

  ctl_st_e st_q;
  ctl_st_e st_d;

  // next-state and output decode
  always_comb begin
    st_d      = st_q;
    ld_ops    = 1'b0;
    alu_fn    = FN_PASS_B;
    alu_c0    = 1'b0;
    b_src     = BSRC_ZERO;
    r1_we     = 1'b0;
    r2_we     = 1'b0;
    cnt_we    = 1'b0;
    cnt_ld_r1 = 1'b0;
    done      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ld_ops = 1'b1;
          r1_we  = 1'b1;
          r2_we  = 1'b1;
          st_d   = ST_SUM;
        end
      end
      ST_SUM: begin
        // R2 <= n + a ; counter <= n
        alu_fn    = FN_ADD_AB;
        b_src     = BSRC_R2;
        r2_we     = 1'b1;
        cnt_we    = 1'b1;
        cnt_ld_r1 = 1'b1;
        st_d      = ST_CLR;
      end
      ST_CLR: begin
        // R1 <= 0 via pass-B of the zero source
        alu_fn = FN_PASS_B;
        b_src  = BSRC_ZERO;
        r1_we  = 1'b1;
        st_d   = ST_TEST;
      end
      ST_TEST: begin
        st_d = cnt_zero ? ST_FIN : ST_ACC;
      end
      ST_ACC: begin
        // R1 <= R1 + m
        alu_fn = FN_ADD_AB;
        b_src  = BSRC_R2;
        r1_we  = 1'b1;
        st_d   = ST_STEP;
      end
      ST_STEP: begin
        // counter <= counter - 1
        alu_fn = FN_DEC_B;
        alu_c0 = 1'b1;
        b_src  = BSRC_CNT;
        cnt_we = 1'b1;
        st_d   = ST_TEST;
      end
      ST_FIN: begin
        done = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/repadd_mul.sv
module repadd_mul
  import repadd_mul_pkg::*;
#(
  parameter int OW = 8,
  parameter int DW = 2*OW+1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OW-1:0]   n_in,
  input  logic [OW-1:0]   a_in,
  output logic            done,
  output logic [DW-1:0]   result
);

  logic          rst_sync_n;
  logic          ld_ops;
  alu_fn_e       alu_fn;
  logic          alu_c0;
  bsrc_e         b_src;
  logic          r1_we;
  logic          r2_we;
  logic          cnt_we;
  logic          cnt_ld_r1;
  logic          cnt_zero;
  logic [DW-1:0] alu_a;
  logic [DW-1:0] alu_b;
  logic [DW-1:0] alu_y;

  repadd_mul_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  repadd_mul_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .cnt_zero  (cnt_zero),
    .ld_ops    (ld_ops),
    .alu_fn    (alu_fn),
    .alu_c0    (alu_c0),
    .b_src     (b_src),
    .r1_we     (r1_we),
    .r2_we     (r2_we),
    .cnt_we    (cnt_we),
    .cnt_ld_r1 (cnt_ld_r1),
    .done      (done)
  );

  repadd_mul_datapath #(.OW(OW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .n_in      (n_in),
    .a_in      (a_in),
    .ld_ops    (ld_ops),
    .b_src     (b_src),
    .r1_we     (r1_we),
    .r2_we     (r2_we),
    .cnt_we    (cnt_we),
    .cnt_ld_r1 (cnt_ld_r1),
    .alu_y     (alu_y),
    .alu_a     (alu_a),
    .alu_b     (alu_b),
    .r1_q      (result),
    .cnt_zero  (cnt_zero)
  );

  repadd_mul_alu #(.DW(DW)) u_alu (
    .fn (alu_fn),
    .a  (alu_a),
    .b  (alu_b),
    .c0 (alu_c0),
    .y  (alu_y)
  );

endmodule

// File: rtl/repadd_mul_chk.sv
module repadd_mul_chk
  import repadd_mul_pkg::*;
#(
  parameter int OW = 8,
  parameter int DW = 2*OW+1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [OW-1:0]   n_in,
  input logic [OW-1:0]   a_in,
  input logic            done,
  input logic [DW-1:0]   result,
  input alu_fn_e         alu_fn,
  input logic [DW-1:0]   alu_a,
  input logic [DW-1:0]   alu_b,
  input logic            alu_c0,
  input logic [DW-1:0]   alu_y
);

  localparam int PADW = DW - OW;

  logic          busy_q;
  logic [OW-1:0] n_cap;
  logic [OW-1:0] a_cap;
  int            lat_q;
  logic [DW-1:0] n_ext;
  logic [DW-1:0] exp_prod;
  logic [DW-1:0] c0_ext;

  assign n_ext    = {{PADW{1'b0}}, n_cap};
  assign exp_prod = n_ext * (n_ext + {{PADW{1'b0}}, a_cap});
  assign c0_ext   = {{(DW-1){1'b0}}, alu_c0};

  // independent model of which start is accepted, and elapsed edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      n_cap  <= '0;
      a_cap  <= '0;
      lat_q  <= 0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        n_cap  <= n_in;
        a_cap  <= a_in;
        lat_q  <= 0;
      end
    end else if (done) begin
      busy_q <= 1'b0;
    end else begin
      lat_q <= lat_q + 1;
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == exp_prod));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == 3 + 3 * int'(n_cap)));

  // R5
  done_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_q);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(result));

  // R7
  alu_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == FN_PASS_B) |-> (alu_y == alu_b));

  // R7
  alu_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == FN_DEC_B) |-> (alu_y + c0_ext == alu_b));

  // R7
  alu_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == FN_INC_B) |-> (alu_y - c0_ext == alu_b));

  // R7
  alu_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == FN_ADD_AB) |-> (alu_y - alu_a == alu_b));

endmodule

bind repadd_mul repadd_mul_chk #(.OW(OW), .DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .start  (start),
  .n_in   (n_in),
  .a_in   (a_in),
  .done   (done),
  .result (result),
  .alu_fn (alu_fn),
  .alu_a  (alu_a),
  .alu_b  (alu_b),
  .alu_c0 (alu_c0),
  .alu_y  (alu_y)
);

// File: tb/tb_repadd_mul.sv
module tb_repadd_mul;

  localparam int OW = 8;
  localparam int DW = 2*OW+1;
  localparam int NV = 10;

  // stimulus n, a and expected product n*(n+a)
  localparam int VN [NV] = '{3, 1, 0, 5, 255, 10, 2, 255, 7, 0};
  localparam int VA [NV] = '{4, 0, 9, 5, 255, 0, 253, 0, 1, 0};
  localparam int VS [NV] = '{21, 1, 0, 50, 130050, 100, 510, 65025, 56, 0};

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [OW-1:0] n_in;
  logic [OW-1:0] a_in;
  logic          done;
  logic [DW-1:0] result;

  int n_checks;
  int n_fail;
  bit finished;

  repadd_mul #(.OW(OW), .DW(DW)) dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .n_in   (n_in),
    .a_in   (a_in),
    .done   (done),
    .result (result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one calculation; optional interfering start at edge k == poke_at
  task automatic run_op(input int n, input int a, input int exp_s, input int poke_at);
    int  k;
    bit  seen;
    @(negedge clk);
    n_in  = OW'(n);
    a_in  = OW'(a);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    k    = 0;
    seen = 1'b0;
    while (!seen && k < 2000) begin
      @(posedge clk);
      #1;
      k++;
      start = 1'b0;
      if (done) begin
        seen = 1'b1;
      end else if (k == poke_at) begin
        n_in  = 8'd9;
        a_in  = 8'd9;
        start = 1'b1;
      end
    end
    start = 1'b0;
    chk(seen, "R3 done seen", seen, 1);
    chk(k == 3 + 3*n, (n == 0) ? "R8 latency n=0" : "R4 latency", k, 3 + 3*n);
    chk(result == DW'(exp_s), (poke_at >= 0) ? "R5 result with busy start" : "R2 R7 product", result, exp_s);
    @(posedge clk);
    #1;
    chk(!done, "R3 done one cycle", done, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    start    = 1'b0;
    n_in     = '0;
    a_in     = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!done && result == '0, "R1 state in reset", result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(!done, "R1 done after reset", done, 0);
    chk(result == '0, "R1 result after reset", result, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      run_op(VN[i], VA[i], VS[i], -1);
    end

    // R5: start with new operands mid-loop is ignored
    run_op(5, 5, 50, 7);
    run_op(4, 1, 20, 3);

    // R6: result held while idle and operands change
    begin
      logic [DW-1:0] held;
      held = result;
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        n_in = OW'(j * 37 + 1);
        a_in = OW'(j * 11 + 5);
      end
      @(posedge clk);
      #1;
      chk(result == held, "R6 result held", result, held);
      chk(!done, "R6 no done while idle", done, 0);
    end

    // R1: reset mid-run abandons the calculation
    @(negedge clk);
    n_in  = 8'd200;
    a_in  = 8'd10;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk(result == '0, "R1 result cleared by reset", result, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      bit any_done;
      any_done = 1'b0;
      for (int j = 0; j < 20; j++) begin
        @(posedge clk);
        #1;
        if (done) any_done = 1'b1;
      end
      chk(!any_done, "R1 no done after aborted run", any_done, 0);
      chk(result == '0, "R1 result stays zero", result, 0);
    end

    // recovery and back-to-back runs
    run_op(6, 2, 48, -1);
    run_op(0, 255, 0, -1);
    run_op(255, 255, 130050, -1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule